// File: doc/BRIEF.md
# Marginal-Utility Way Allocator

This block divides the ways of a shared last-level cache among the cores that share it. Each core has a profiler holding a histogram of hits against LRU stack distance. Entry d of that histogram counts the hits that a core would gain from its (d+1)-th way. A start pulse begins a greedy search. Every core first receives one way. After that, one way per clock cycle goes to the core whose next way would add the most hits. A core stops receiving ways once it reaches a fixed cap, which is 9/16 of the total ways.

The block reads each core's histogram through a read port of its own. The block drives the distance index on that port and the profiler returns the count for that index in the same cycle. The search ends when every way has been handed out or when every core has reached its cap. At that point a done flag pulses for one cycle. The allocation outputs then hold their value until the next accepted start. A higher-level scheduler normally issues one start per epoch, which is about 100 million instructions. The block has no streaming data path: the start input, the done flag, the read ports and the allocation outputs are plain level or pulse signals with no back-pressure.

Top module: `mu_way_allocator`

## Requirements
- R1: After reset, every allocation field reads 0 and done is low.
- R2: A start sampled high while idle sets every core's allocation to exactly 1 on that clock edge.
- R3: Core c's read index, hc_idx[c*IDX_W +: IDX_W], always presents that core's current allocation as the stack distance it is asking about.
- R4: Each grant adds one way to the eligible core whose hit count at its current allocation is the largest.
- R5: When several eligible cores have equal gains, the lowest-numbered core wins the grant.
- R6: No core's allocation, alloc[c*ALLOC_W +: ALLOC_W], ever exceeds CAP = NUM_WAYS*9/16, which is 9 with the default parameters. A core at the cap is no longer eligible.
- R7: At most one way is granted per cycle. Done is raised on the cycle after the last grant, so the latency from the start edge to done is (number of grants)+1 cycles, and done lasts exactly one cycle.
- R8: When done rises, the allocations sum to min(NUM_WAYS, NUM_CORES*CAP).
- R9: While the block is idle and start is low, the allocation outputs do not change, whatever the histograms do.
- R10: A start pulse during a search is ignored. The result and the timing of done are the same as without the pulse.
- R11: A grant is made even when every gain is zero, so all ways are still handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search when the block is idle |
| done | output | 1 | One-cycle pulse at the end of a search |
| hc_idx | output | NUM_CORES*IDX_W | Per-core stack-distance index into the hit histogram |
| hc_data | input | NUM_CORES*CNT_W | Per-core hit count at hc_idx, valid in the same cycle |
| alloc | output | NUM_CORES*ALLOC_W | Per-core way allocation |

## Verification
The bound checker checks the following on every cycle:
- the per-core cap;
- the single-grant-per-cycle growth of the allocation total;
- that the total never shrinks mid-search, so a stray start cannot reset it;
- that a start taken while idle resets every core to one way;
- that done is a one-cycle pulse;
- that the allocation total is correct when done rises;
- that the outputs hold while idle.

Which core wins each grant depends on the histogram contents, so only the bench scenarios can show it. The bench covers a dominant core running into its cap, all-equal and all-zero histograms that exercise the tie rule, and a mixed pattern. The bench also checks the latency to done and that the result holds steady after the histograms change.

// File: rtl/mu_alloc_pkg.sv
package mu_alloc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } alloc_state_e;

  function automatic int unsigned cap_ways(input int unsigned ways,
                                           input int unsigned num,
                                           input int unsigned den);
    int unsigned v;
    v = (ways * num) / den;
    if (v < 1) v = 1;
    return v;
  endfunction
endpackage

// File: rtl/mu_alloc_slot.sv
module mu_alloc_slot #(
  parameter int unsigned NUM_WAYS = 16,
  parameter int unsigned CAP      = 9,
  parameter int unsigned ALLOC_W  = 5,
  parameter int unsigned IDX_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               grant,
  output logic [ALLOC_W-1:0] alloc,
  output logic [IDX_W-1:0]   idx,
  output logic               eligible
);
  localparam logic [ALLOC_W-1:0] CAP_V  = ALLOC_W'(CAP);
  localparam logic [ALLOC_W-1:0] LAST_V = ALLOC_W'(NUM_WAYS - 1);

  logic [ALLOC_W-1:0] alloc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q <= '0;
    end else if (init) begin
      alloc_q <= ALLOC_W'(1);
    end else if (grant) begin
      alloc_q <= alloc_q + ALLOC_W'(1);
    end
  end

  always_comb begin
    alloc    = alloc_q;
    eligible = (alloc_q < CAP_V);
    if (alloc_q > LAST_V) idx = IDX_W'(NUM_WAYS - 1);
    else                  idx = alloc_q[IDX_W-1:0];
  end
endmodule

// File: rtl/mu_alloc_pick.sv
module mu_alloc_pick #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CNT_W     = 16
) (
  input  logic [NUM_CORES*CNT_W-1:0] gain,
  input  logic [NUM_CORES-1:0]       eligible,
  output logic                       any_eligible,
  output logic [NUM_CORES-1:0]       winner_oh
);
  logic [CNT_W-1:0] best;

  always_comb begin
    any_eligible = 1'b0;
    best         = '0;
    winner_oh    = '0;
    for (int c = 0; c < int'(NUM_CORES); c++) begin
      if (eligible[c] && (!any_eligible || (gain[c*CNT_W +: CNT_W] > best))) begin
        any_eligible = 1'b1;
        best         = gain[c*CNT_W +: CNT_W];
        winner_oh    = '0;
        winner_oh[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mu_alloc_ctrl.sv
module mu_alloc_ctrl
  import mu_alloc_pkg::*;
#(
  parameter int unsigned NUM_WAYS  = 16,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned REM_W     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic any_eligible,
  output logic init,
  output logic step,
  output logic done
);
  localparam logic [REM_W-1:0] SPARE = REM_W'(NUM_WAYS - NUM_CORES);

  alloc_state_e     st_q;
  logic [REM_W-1:0] rem_q;
  logic             done_q;
  logic             finish;

  assign finish = (rem_q == '0) || !any_eligible;
  assign init   = (st_q == ST_IDLE) && start;
  assign step   = (st_q == ST_RUN) && !finish;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_RUN;
            rem_q <= SPARE;
          end
        end
        ST_RUN: begin
          if (finish) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            rem_q <= rem_q - REM_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mu_way_allocator.sv
module mu_way_allocator
  import mu_alloc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_WAYS  = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CAP_NUM   = 9,
  parameter int unsigned CAP_DEN   = 16,
  parameter int unsigned IDX_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  parameter int unsigned ALLOC_W   = $clog2(NUM_WAYS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         done,
  output logic [NUM_CORES*IDX_W-1:0]   hc_idx,
  input  logic [NUM_CORES*CNT_W-1:0]   hc_data,
  output logic [NUM_CORES*ALLOC_W-1:0] alloc
);
  localparam int unsigned CAP = cap_ways(NUM_WAYS, CAP_NUM, CAP_DEN);

  logic                 init;
  logic                 step;
  logic                 any_eligible;
  logic [NUM_CORES-1:0] eligible;
  logic [NUM_CORES-1:0] winner_oh;

  mu_alloc_ctrl #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_CORES(NUM_CORES),
    .REM_W    (ALLOC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .any_eligible(any_eligible),
    .init        (init),
    .step        (step),
    .done        (done)
  );

  mu_alloc_pick #(
    .NUM_CORES(NUM_CORES),
    .CNT_W    (CNT_W)
  ) u_pick (
    .gain        (hc_data),
    .eligible    (eligible),
    .any_eligible(any_eligible),
    .winner_oh   (winner_oh)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    mu_alloc_slot #(
      .NUM_WAYS(NUM_WAYS),
      .CAP     (CAP),
      .ALLOC_W (ALLOC_W),
      .IDX_W   (IDX_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (init),
      .grant   (step && winner_oh[c]),
      .alloc   (alloc[c*ALLOC_W +: ALLOC_W]),
      .idx     (hc_idx[c*IDX_W +: IDX_W]),
      .eligible(eligible[c])
    );
  end
endmodule

// File: rtl/mu_way_allocator_chk.sv
module mu_way_allocator_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_WAYS  = 16,
  parameter int unsigned CAP_NUM   = 9,
  parameter int unsigned CAP_DEN   = 16,
  parameter int unsigned ALLOC_W   = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         done,
  input logic [NUM_CORES*ALLOC_W-1:0] alloc
);
  localparam int unsigned CAP   = mu_alloc_pkg::cap_ways(NUM_WAYS, CAP_NUM, CAP_DEN);
  localparam int unsigned TOTAL = (NUM_WAYS < NUM_CORES * CAP) ? NUM_WAYS : NUM_CORES * CAP;
  localparam int unsigned SUM_W = $clog2(NUM_CORES * NUM_WAYS + 1) + 1;
  localparam logic [ALLOC_W-1:0] CAP_V   = ALLOC_W'(CAP);
  localparam logic [SUM_W-1:0]   TOTAL_V = SUM_W'(TOTAL);

  logic             run_q;
  logic             idle_now;
  logic [SUM_W-1:0] sum;

  assign idle_now = !run_q || done;

  always_comb begin
    sum = '0;
    for (int c = 0; c < int'(NUM_CORES); c++) sum = sum + SUM_W'(alloc[c*ALLOC_W +: ALLOC_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  run_q <= 1'b0;
    else if (idle_now && start)  run_q <= 1'b1;
    else if (done)               run_q <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_cap
    // R6
    cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc[c*ALLOC_W +: ALLOC_W] <= CAP_V);
    // R2
    start_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_now && start) |=> (alloc[c*ALLOC_W +: ALLOC_W] == ALLOC_W'(1)));
  end

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done) |=> (sum <= $past(sum) + SUM_W'(1)));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done) |=> (sum >= $past(sum)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum == TOTAL_V));
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && !start) |=> $stable(alloc));
endmodule

bind mu_way_allocator mu_way_allocator_chk #(
  .NUM_CORES(NUM_CORES),
  .NUM_WAYS (NUM_WAYS),
  .CAP_NUM  (CAP_NUM),
  .CAP_DEN  (CAP_DEN),
  .ALLOC_W  (ALLOC_W)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .done (done),
  .alloc(alloc)
);

// File: tb/mu_way_allocator_test.sv
`timescale 1ns/1ps
module mu_way_allocator_test;
  localparam int NC   = 4;
  localparam int NW   = 16;
  localparam int CW   = 16;
  localparam int IW   = 4;
  localparam int AW   = 5;
  localparam int CAP  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done;
  logic [NC*IW-1:0] hc_idx;
  logic [NC*CW-1:0] hc_data;
  logic [NC*AW-1:0] alloc;

  int hist [NC][NW];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [NC*AW-1:0] exp_q [$];
  logic [NC*AW-1:0] last_exp;

  always #2.5 clk = ~clk;

  mu_way_allocator uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .hc_idx (hc_idx),
    .hc_data(hc_data),
    .alloc  (alloc)
  );

  always_comb begin
    for (int c = 0; c < NC; c++)
      hc_data[c*CW +: CW] = CW'(hist[c][int'(hc_idx[c*IW +: IW])]);
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference: greedy grant by largest hit count at the current allocation,
  // lowest core on ties, capped cores excluded.
  function automatic int model(output logic [NC*AW-1:0] res);
    int a [NC];
    int rem, grants;
    grants = 0;
    for (int c = 0; c < NC; c++) a[c] = 1;
    rem = NW - NC;
    while (rem > 0) begin
      int best, bg;
      best = -1; bg = -1;
      for (int c = 0; c < NC; c++)
        if (a[c] < CAP && hist[c][a[c]] > bg) begin best = c; bg = hist[c][a[c]]; end
      if (best < 0) break;
      a[best]++; rem--; grants++;
    end
    res = '0;
    for (int c = 0; c < NC; c++) res[c*AW +: AW] = AW'(a[c]);
    return grants;
  endfunction

  // Scoreboard monitor: compare each finished search with the queued result.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected done", 1, 0);
      end else begin
        logic [NC*AW-1:0] e;
        e = exp_q.pop_front();
        for (int c = 0; c < NC; c++)
          check("R4/R5/R6 allocation", int'(alloc[c*AW +: AW]), int'(e[c*AW +: AW]));
      end
    end
  end

  task automatic run_case(string name, bit poke);
    int grants, k;
    logic [NC*AW-1:0] e;
    grants = model(e);
    last_exp = e;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    k = 0;
    forever begin
      @(negedge clk);
      start = poke && (k == 4);
      if (k == 0)
        for (int c = 0; c < NC; c++)
          check("R2 one way each", int'(alloc[c*AW +: AW]), 1);
      if (done) break;
      k++;
    end
    start = 1'b0;
    check({"R7 latency ", name}, k, grants + 1);
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    for (int c = 0; c < NC; c++)
      check("R3 index follows allocation", int'(hc_idx[c*IW +: IW]), int'(alloc[c*AW +: AW]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done low", int'(done), 0);
    for (int c = 0; c < NC; c++) check("R1 alloc zero", int'(alloc[c*AW +: AW]), 0);
    rst_n = 1'b1;

    // Dominant core 0 runs into the cap (R4, R6)
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < NW; d++) hist[c][d] = (c == 0) ? 1000 - d : 10 * c + d;
    run_case("dominant", 0);
    check("R6 core0 capped", int'(alloc[0 +: AW]), CAP);

    // All equal: ties resolve to lowest core (R5)
    for (int c = 0; c < NC; c++) for (int d = 0; d < NW; d++) hist[c][d] = 5;
    run_case("ties", 0);
    check("R5 tie core1", int'(alloc[AW +: AW]), 5);

    // All zero: grants still made (R11)
    for (int c = 0; c < NC; c++) for (int d = 0; d < NW; d++) hist[c][d] = 0;
    run_case("zero", 0);
    begin
      int s; s = 0;
      for (int c = 0; c < NC; c++) s += int'(alloc[c*AW +: AW]);
      check("R11 R8 all ways given", s, NW);
    end

    // Mixed pattern (R4)
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < NW; d++) hist[c][d] = ((c * 7 + d * 3) % 11) * 10 + c;
    run_case("mixed", 0);

    // Start during search ignored (R10)
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < NW; d++) hist[c][d] = 200 - 9 * d + ((c * 5) % 7);
    run_case("poke", 1);

    // Hold while idle despite histogram change (R9)
    for (int c = 0; c < NC; c++) for (int d = 0; d < NW; d++) hist[c][d] = (c == 3) ? 999 : 0;
    repeat (10) @(negedge clk);
    for (int c = 0; c < NC; c++)
      check("R9 hold idle", int'(alloc[c*AW +: AW]), int'(last_exp[c*AW +: AW]));
    check("R7 no extra done", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule